// File: doc/BRIEF.md
# CAN Receive Filter with Dual Frame Buffers

This block sits between a CAN bit-stream receiver and the host processor. The host programs an 8-bit identifier code and an 8-bit don't-care mask through a byte-wide register port. Each incoming frame is announced by a start pulse and then delivered one byte at a time. The first byte carries the upper eight identifier bits and is tested against the code and mask. A frame that passes is copied into one of two frame buffers. A frame that fails leaves no trace.

The receiver reports the end of a frame as either correct completion or abort. Only a correctly completed frame marks its buffer as full and may raise the receive interrupt. The host always sees the older full buffer on a separate byte-read port, and frees it with a release command. Frames that the node transmits itself arrive on the same handshake and are treated the same way. Buffer availability is sampled at frame start, so a frame that finds no free buffer flags a data overrun even if the node later loses arbitration.

Top module: `can_rx_filter`

## Requirements
- R1: After reset, the control register (address 0; bit 0 = reset request, bit 1 = receive interrupt enable) reads 0x01, and the status (address 2), interrupt (address 3), code (address 4) and mask (address 5) registers read 0x00. While reset request is 1, code and mask are written and read back through their addresses.
- R2: A write to the code or mask register while reset request is 0 leaves the register unchanged.
- R3: A frame is accepted when, at every bit position i where mask bit i is 0, identifier bit (3+i) equals code bit i. Mask bits of 1 are don't care, so an all-ones mask accepts every identifier.
- R4: An accepted frame is stored in order. Buffer byte 0 holds ID.10..ID.3. Byte 1 holds {ID.2..ID.0, RTR, length code[3:0]}. Bytes 2 and up hold the data bytes. The host reads these through rxb_sel/rxb_data from the older full buffer.
- R5: The number of stored data bytes is the length code, capped at 8. Later bytes are not stored, and rxb_data reads 0x00 at any index at or beyond 2 plus that count.
- R6: Status bit 0 (buffer full) rises only at the edge that registers frm_done. An aborted frame releases its buffer and does not change status bit 0 or the interrupt.
- R7: When an accepted frame finds no empty buffer, status bit 1 (data overrun) is set and the frame is not stored. Writing a 1 to command bit 3 (address 1) clears the overrun bit.
- R8: A completed frame sets the receive interrupt flag (interrupt register bit 0, driven on rx_irq) only when the enable bit is 1. A read of address 3 with reg_rd clears the flag.
- R9: Writing a 1 to command bit 2 (address 1) frees the older full buffer and exposes the next one. Status bit 0 stays 1 while any buffer is full.
- R10: While reset request is 1, both buffers are empty, status bit 0 reads 0, and frames are neither stored nor counted as overrun.
- R11: A frame that fails the acceptance test changes neither the buffers, the overrun bit nor the interrupt.
- R12: Buffer availability is sampled at frm_start. A buffer that is released after the start pulse does not let that frame be stored, and the frame is counted as an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the interrupt flag at address 3) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| frm_start | input | 1 | Pulse: a new frame begins |
| frm_byte_vld | input | 1 | Frame byte valid |
| frm_byte | input | 8 | Frame byte: ID high, ID low/RTR/length, then data |
| frm_done | input | 1 | Pulse: frame finished correctly |
| frm_abort | input | 1 | Pulse: frame aborted |
| rxb_sel | input | 4 | Byte index into the older full buffer |
| rxb_data | output | 8 | Selected buffer byte, 0 when no buffer is full |
| rx_irq | output | 1 | Receive interrupt flag |

## Verification
A register write takes effect at the next rising edge, while reg_rdata and rxb_data follow their selects combinationally in the same cycle. The full and overrun bits and rx_irq change at the rising edge that registers frm_done or the first frame byte. The bench therefore changes all inputs on falling edges and samples outputs 1 ns after the falling edge that follows the registering edge, which is where every frame and register task returns. Overrun and availability are checked with release commands placed before and after frm_start, so the snapshot timing is seen directly.

// File: rtl/can_acf_pkg.sv
// Package: shared constants, frame-tracking state and length helper for the
// CAN receive filter. Assumes 8-bit bytes and a two-byte descriptor.
package can_acf_pkg;
    parameter int MAX_DATA   = 8;
    localparam int HDR_BYTES  = 2;
    localparam int SLOT_BYTES = HDR_BYTES + MAX_DATA;
    localparam int IDX_W      = $clog2(SLOT_BYTES + 1);

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_CMD  = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_INT  = 3'd3;
    localparam logic [2:0] A_CODE = 3'd4;
    localparam logic [2:0] A_MASK = 3'd5;

    localparam int B_RRQ = 0;
    localparam int B_IE  = 1;
    localparam int B_REL = 2;
    localparam int B_CLR = 3;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_WAIT_ID,
        FS_CAPTURE,
        FS_DROP
    } frm_state_e;

    // Stored byte count for a length code: header plus capped data bytes.
    function automatic logic [IDX_W-1:0] frame_len(input logic [3:0] dlc);
        logic [IDX_W-1:0] data_n;
        data_n = (int'(dlc) > MAX_DATA) ? IDX_W'(MAX_DATA) : IDX_W'(dlc);
        return IDX_W'(HDR_BYTES) + data_n;
    endfunction
endpackage

// File: rtl/can_acf_match.sv
// Module: acceptance test of the upper identifier bits against code and mask.
// Purely combinational; a mask bit of 1 marks a don't-care position.
module can_acf_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] id_hi,
    input  logic [W-1:0] code,
    input  logic [W-1:0] mask,
    output logic         accept
);
    logic [W-1:0] bit_ok;

    // One comparator per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_ok[i] = mask[i] | ~(id_hi[i] ^ code[i]);
    end

    assign accept = &bit_ok;

    // R3: an all-don't-care mask must accept any identifier.
    always_comb begin
        if (&mask) begin
            p_mask_all_open_r3: assert (accept);
        end
    end
endmodule

// File: rtl/can_acf_rxbuf.sv
// Module: frame storage, NUM_BUF slots of header plus data bytes.
// One write port fed by the frame tracker, one combinational read port.
// Reads at or beyond the stored length of the slot return zero.
// Assumes wr_idx stays below the slot size (checked below).
module can_acf_rxbuf
    import can_acf_pkg::*;
#(
    parameter int NUM_BUF = 2,
    localparam int SLOT_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_data
);
    logic [7:0] slot_rd  [NUM_BUF];
    logic [3:0] slot_dlc [NUM_BUF];

    for (genvar s = 0; s < NUM_BUF; s++) begin : g_slot
        logic [7:0] bytes_q [SLOT_BYTES];

        // Byte write into this slot.
        always_ff @(posedge clk) begin
            if (wr_en && wr_slot == SLOT_W'(s) && wr_idx < IDX_W'(SLOT_BYTES)) begin
                bytes_q[wr_idx] <= wr_data;
            end
        end

        assign slot_rd[s]  = (rd_idx < IDX_W'(SLOT_BYTES)) ? bytes_q[rd_idx] : 8'h00;
        assign slot_dlc[s] = bytes_q[1][3:0];
    end

    // Read mux gated by the stored frame length.
    always_comb begin
        if (rd_idx < frame_len(slot_dlc[rd_slot])) begin
            rd_data = slot_rd[rd_slot];
        end else begin
            rd_data = 8'h00;
        end
    end

    // R5: the tracker never writes past the slot.
    p_wr_in_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(SLOT_BYTES)));
endmodule

// File: rtl/can_rx_filter.sv
// Module: CAN acceptance filter with buffered receive path (top).
// Holds the control, code and mask registers. Tracks each frame from its
// start pulse and claims a buffer when the identifier byte passes the
// filter. Keeps the ring of full buffers and the overrun and interrupt flags.
// Assumes frames do not overlap and that done/abort never share a cycle with
// a byte.
module can_rx_filter
    import can_acf_pkg::*;
#(
    parameter int NUM_BUF = 2,
    localparam int SLOT_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int CNT_W  = $clog2(NUM_BUF + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       frm_start,
    input  logic       frm_byte_vld,
    input  logic [7:0] frm_byte,
    input  logic       frm_done,
    input  logic       frm_abort,
    input  logic [3:0] rxb_sel,
    output logic [7:0] rxb_data,
    output logic       rx_irq
);
    logic              rrq_q, ie_q, ovr_q, rxint_q, avail_q;
    logic [7:0]        code_q, mask_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SLOT_W-1:0] rd_ptr_q, fill_slot_q, new_slot;
    logic [IDX_W-1:0]  idx_q;
    logic [3:0]        dlc_q;
    frm_state_e        state_q;

    logic              accept, claim, ovr_set, store, complete, pop;
    logic              cmd_wr, filt_wr;
    logic [SLOT_W:0]   slot_sum;
    logic [7:0]        buf_rd;

    assign cmd_wr   = reg_wr && reg_addr == A_CMD;
    assign filt_wr  = reg_wr && rrq_q;
    assign pop      = cmd_wr && reg_wdata[B_REL] && cnt_q != '0;

    can_acf_match #(.W(8)) u_match (
        .id_hi  (frm_byte),
        .code   (code_q),
        .mask   (mask_q),
        .accept (accept)
    );

    // Next empty slot: the one after the full ones in ring order.
    assign slot_sum = {1'b0, rd_ptr_q} + (SLOT_W+1)'(cnt_q);
    assign new_slot = (slot_sum >= (SLOT_W+1)'(NUM_BUF))
                    ? SLOT_W'(slot_sum - (SLOT_W+1)'(NUM_BUF))
                    : SLOT_W'(slot_sum);

    // Per-cycle frame decisions.
    always_comb begin
        claim    = !rrq_q && state_q == FS_WAIT_ID && frm_byte_vld && accept && avail_q;
        ovr_set  = !rrq_q && state_q == FS_WAIT_ID && frm_byte_vld && accept && !avail_q;
        complete = !rrq_q && state_q == FS_CAPTURE && frm_done;
        store    = claim || (!rrq_q && state_q == FS_CAPTURE && frm_byte_vld &&
                   (idx_q < IDX_W'(HDR_BYTES) || idx_q < frame_len(dlc_q)));
    end

    // Control and filter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrq_q  <= 1'b1;
            ie_q   <= 1'b0;
            code_q <= 8'h00;
            mask_q <= 8'h00;
        end else begin
            if (reg_wr && reg_addr == A_CTRL) begin
                rrq_q <= reg_wdata[B_RRQ];
                ie_q  <= reg_wdata[B_IE];
            end
            if (filt_wr && reg_addr == A_CODE) code_q <= reg_wdata;
            if (filt_wr && reg_addr == A_MASK) mask_q <= reg_wdata;
        end
    end

    // Frame tracker: snapshot availability at start, then capture or drop.
    always_ff @(posedge clk) begin
        if (!rst_n || rrq_q) begin
            state_q     <= FS_IDLE;
            avail_q     <= 1'b0;
            fill_slot_q <= '0;
            idx_q       <= '0;
            dlc_q       <= 4'd0;
        end else if (frm_start) begin
            state_q <= FS_WAIT_ID;
            avail_q <= cnt_q < CNT_W'(NUM_BUF);
        end else begin
            if (state_q == FS_WAIT_ID && frm_byte_vld) begin
                state_q     <= claim ? FS_CAPTURE : FS_DROP;
                fill_slot_q <= new_slot;
            end
            if (frm_done || frm_abort) state_q <= FS_IDLE;
            if (store) idx_q <= claim ? IDX_W'(1) : idx_q + IDX_W'(1);
            if (store && !claim && idx_q == IDX_W'(1)) dlc_q <= frm_byte[3:0];
        end
    end

    // Ring of full buffers: count and oldest pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || rrq_q) begin
            cnt_q    <= '0;
            rd_ptr_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(complete) - CNT_W'(pop);
            if (pop) rd_ptr_q <= (rd_ptr_q == SLOT_W'(NUM_BUF - 1)) ? '0 : rd_ptr_q + SLOT_W'(1);
        end
    end

    // Overrun and receive interrupt flags; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q   <= 1'b0;
            rxint_q <= 1'b0;
        end else begin
            if (ovr_set)                                   ovr_q <= 1'b1;
            else if (cmd_wr && reg_wdata[B_CLR])           ovr_q <= 1'b0;
            if (complete && ie_q)                          rxint_q <= 1'b1;
            else if (reg_rd && reg_addr == A_INT)          rxint_q <= 1'b0;
        end
    end

    can_acf_rxbuf #(.NUM_BUF(NUM_BUF)) u_rxbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store),
        .wr_slot (claim ? new_slot : fill_slot_q),
        .wr_idx  (claim ? '0 : idx_q),
        .wr_data (frm_byte),
        .rd_slot (rd_ptr_q),
        .rd_idx  (rxb_sel),
        .rd_data (buf_rd)
    );

    // Register read mux.
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {6'd0, ie_q, rrq_q};
            A_STAT:  reg_rdata = {6'd0, ovr_q, cnt_q != '0};
            A_INT:   reg_rdata = {7'd0, rxint_q};
            A_CODE:  reg_rdata = code_q;
            A_MASK:  reg_rdata = mask_q;
            default: reg_rdata = 8'h00;
        endcase
    end

    assign rxb_data = (cnt_q != '0) ? buf_rd : 8'h00;
    assign rx_irq   = rxint_q;

    // R2: filter code is frozen outside reset request.
    p_code_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rrq_q && reg_wr && reg_addr == A_CODE) |=> $stable(code_q));
    // R10: reset request empties the buffer ring.
    p_rrq_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rrq_q |=> cnt_q == '0);
    // R8: interrupt only rises while enabled.
    p_irq_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxint_q) |-> $past(ie_q));
    // R6: a buffer only becomes full after a completed frame.
    p_full_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > $past(cnt_q)) |-> $past(frm_done));
    // R9: never more full buffers than exist.
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(NUM_BUF));
endmodule

// File: tb/can_rx_filter_tb.sv
module can_rx_filter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       frm_start = 1'b0, frm_byte_vld = 1'b0, frm_done = 1'b0, frm_abort = 1'b0;
    logic [7:0] frm_byte = '0;
    logic [3:0] rxb_sel = '0;
    logic [7:0] rxb_data;
    logic       rx_irq;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    can_rx_filter u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frm_start(frm_start),
        .frm_byte_vld(frm_byte_vld), .frm_byte(frm_byte), .frm_done(frm_done),
        .frm_abort(frm_abort), .rxb_sel(rxb_sel), .rxb_data(rxb_data), .rx_irq(rx_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd_reg(a, v);
        check(req, v, exp);
    endtask

    task automatic chk_buf(input string req, input logic [3:0] sel, input logic [7:0] exp);
        @(negedge clk); rxb_sel = sel; #1 check(req, rxb_data, exp);
    endtask

    task automatic send_frame(input logic [10:0] id, input logic [3:0] dlc, input int ndata,
                              input logic [7:0] base, input bit abort_it, input bit rel_mid);
        @(negedge clk); frm_start = 1'b1;
        @(negedge clk); frm_start = 1'b0;
        if (rel_mid) begin
            reg_addr = 3'd1; reg_wdata = 8'h04; reg_wr = 1'b1;
            @(negedge clk); reg_wr = 1'b0;
        end
        frm_byte_vld = 1'b1; frm_byte = id[10:3];
        @(negedge clk); frm_byte = {id[2:0], 1'b0, dlc};
        @(negedge clk);
        for (int k = 0; k < ndata; k++) begin
            frm_byte = base + 8'(k);
            @(negedge clk);
        end
        frm_byte_vld = 1'b0;
        if (abort_it) frm_abort = 1'b1; else frm_done = 1'b1;
        @(negedge clk); frm_abort = 1'b0; frm_done = 1'b0;
    endtask

    task automatic t_reset;
        chk_reg("R1 ctrl", 3'd0, 8'h01);
        chk_reg("R1 stat", 3'd2, 8'h00);
        chk_reg("R1 code", 3'd4, 8'h00);
        check("R1 irq", {7'd0, rx_irq}, 8'h00);
    endtask

    task automatic t_filter_regs;
        wr_reg(3'd4, 8'hA5); wr_reg(3'd5, 8'h0F);
        chk_reg("R1 code rw", 3'd4, 8'hA5);
        chk_reg("R1 mask rw", 3'd5, 8'h0F);
        wr_reg(3'd0, 8'h02);
        wr_reg(3'd4, 8'h00); wr_reg(3'd5, 8'hFF);
        chk_reg("R2 code locked", 3'd4, 8'hA5);
        chk_reg("R2 mask locked", 3'd5, 8'h0F);
    endtask

    task automatic t_accept;
        send_frame({8'hA3, 3'b101}, 4'd3, 3, 8'h10, 1'b0, 1'b0);
        chk_reg("R6 full", 3'd2, 8'h01);
        check("R8 irq set", {7'd0, rx_irq}, 8'h01);
        chk_buf("R4 byte0", 4'd0, 8'hA3);
        chk_buf("R4 byte1", 4'd1, 8'hA3);
        chk_buf("R4 data0", 4'd2, 8'h10);
        chk_buf("R4 data2", 4'd4, 8'h12);
        chk_buf("R5 past len", 4'd5, 8'h00);
        chk_reg("R8 int read", 3'd3, 8'h01);
        check("R8 irq cleared", {7'd0, rx_irq}, 8'h00);
    endtask

    task automatic t_reject_and_second;
        send_frame({8'h53, 3'b000}, 4'd1, 1, 8'h77, 1'b0, 1'b0);
        chk_reg("R11 stat", 3'd2, 8'h01);
        chk_buf("R11 buf", 4'd0, 8'hA3);
        check("R11 irq", {7'd0, rx_irq}, 8'h00);
        send_frame({8'hAF, 3'b000}, 4'd12, 10, 8'h20, 1'b0, 1'b0);
        chk_buf("R9 older first", 4'd0, 8'hA3);
        wr_reg(3'd1, 8'h04);
        chk_reg("R9 still full", 3'd2, 8'h01);
        chk_buf("R9 next", 4'd0, 8'hAF);
        chk_buf("R4 desc", 4'd1, 8'h0C);
        chk_buf("R5 cap last", 4'd9, 8'h27);
        chk_buf("R5 cap beyond", 4'd10, 8'h00);
    endtask

    task automatic t_overrun;
        send_frame({8'hA0, 3'b000}, 4'd0, 0, 8'h00, 1'b0, 1'b0);
        send_frame({8'hA1, 3'b000}, 4'd1, 1, 8'h55, 1'b0, 1'b0);
        chk_reg("R7 ovr set", 3'd2, 8'h03);
        chk_buf("R7 not stored", 4'd0, 8'hAF);
        wr_reg(3'd1, 8'h08);
        chk_reg("R7 ovr clr", 3'd2, 8'h01);
    endtask

    task automatic t_snapshot;
        send_frame({8'hA2, 3'b000}, 4'd0, 0, 8'h00, 1'b0, 1'b1);
        chk_reg("R12 ovr", 3'd2, 8'h03);
        chk_buf("R12 exposed", 4'd0, 8'hA0);
        wr_reg(3'd1, 8'h04);
        chk_reg("R12 not stored", 3'd2, 8'h02);
        wr_reg(3'd1, 8'h08);
    endtask

    task automatic t_abort;
        logic [7:0] v;
        rd_reg(3'd3, v);
        send_frame({8'hA4, 3'b000}, 4'd2, 2, 8'h40, 1'b1, 1'b0);
        chk_reg("R6 abort empty", 3'd2, 8'h00);
        check("R6 abort irq", {7'd0, rx_irq}, 8'h00);
    endtask

    task automatic t_mask;
        wr_reg(3'd0, 8'h03); wr_reg(3'd5, 8'hFF); wr_reg(3'd0, 8'h02);
        send_frame({8'h00, 3'b000}, 4'd0, 0, 8'h00, 1'b0, 1'b0);
        chk_reg("R3 all dont care", 3'd2, 8'h01);
        wr_reg(3'd1, 8'h04);
        wr_reg(3'd0, 8'h03); wr_reg(3'd5, 8'h00); wr_reg(3'd4, 8'h3C); wr_reg(3'd0, 8'h02);
        send_frame({8'h3D, 3'b000}, 4'd0, 0, 8'h00, 1'b0, 1'b0);
        chk_reg("R3 exact miss", 3'd2, 8'h00);
        send_frame({8'h3C, 3'b000}, 4'd0, 0, 8'h00, 1'b0, 1'b0);
        chk_reg("R3 exact hit", 3'd2, 8'h01);
    endtask

    task automatic t_rrq_and_ie;
        logic [7:0] v;
        wr_reg(3'd0, 8'h01);
        chk_reg("R10 emptied", 3'd2, 8'h00);
        send_frame({8'h3C, 3'b000}, 4'd0, 0, 8'h00, 1'b0, 1'b0);
        chk_reg("R10 ignored", 3'd2, 8'h00);
        wr_reg(3'd0, 8'h00);
        rd_reg(3'd3, v);
        send_frame({8'h3C, 3'b000}, 4'd0, 0, 8'h00, 1'b0, 1'b0);
        chk_reg("R8 stored no ie", 3'd2, 8'h01);
        check("R8 no irq", {7'd0, rx_irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_filter_regs;
        t_accept;
        t_reject_and_second;
        t_overrun;
        t_snapshot;
        t_abort;
        t_mask;
        t_rrq_and_ie;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule